// File: doc/BRIEF.md
# Mixed-Access Interrupt Status Register

This block holds a 32-bit interrupt status word for a controller that runs either as a host or as a device. Three kinds of bit share the word. Latched event bits capture one-cycle pulses from the event sources and hold them until software writes a 1 to them. Live FIFO-condition bits have no storage of their own. They show the current level of conditions that the FIFO logic drives, so they drop as soon as that logic withdraws the condition once software has serviced the FIFO. A read-only mode bit reports whether the controller is operating as host or device.

A companion mask register sits beside the status word. A single interrupt output is formed from the status and the mask. Status bits that have no meaning in the current mode are suppressed on their way to the output, but they stay visible when software reads the register. Software is expected to clear every latched event after reset and before it sets any mask bit, because several event bits come out of reset already set.

Top module: `evt_status_reg`

## Requirements
- R1: Both `rst` and `soft_rst` return the latched bits to the pattern 0x1400_0020 and the mask register to 0. With `host_mode`=0 and `fifo_cond_i`=0, the status word then reads 0x1400_0020. `soft_rst` takes priority over any write or event in the same cycle.
- R2: A 1 on `evt_i[i]` sets latched bit i at the next clock edge. Latched bits are bits 1, 2, 3, 5 and 10 to 31. The bit stays set until it is cleared.
- R3: Writing the status word at offset 0x014 clears each latched bit whose write-data bit is 1. Write-data bits that are 0 leave their bits unchanged.
- R4: If an event and a write-1 clear reach the same latched bit in the same cycle, the bit stays set.
- R5: Bits 4, 6 and 7 read the live value of `fifo_cond_i` at those positions. Writes and `evt_i` have no effect on these bits.
- R6: Bit 0 reads 1 in host mode (`host_mode`=1) and 0 in device mode. Writes to bit 0 are ignored.
- R7: Bits 8 and 9 are reserved and always read 0, even when `evt_i` pulses at those positions.
- R8: The mask register at offset 0x018 reads back all 32 bits that were last written to it.
- R9: `irq` is the OR, over bits 1 to 31, of status AND mask. Host-only bits (7, 24, 25) are forced to 0 in device mode, and device-only bits (12 to 19) are forced to 0 in host mode. Bit 0 never contributes. Reading the status word is not affected by this mode gating.
- R10: `rdata` is 0 whenever `rd_en` is low or the address is neither 0x014 nor 0x018. Writes to any other address change nothing.
- R11: `irq` has no register of its own. It changes in the same cycle as the status bit or mask bit that drives it, and it follows a live FIFO bit with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Full soft reset, synchronous, same effect as rst |
| host_mode | input | 1 | 1 when the controller runs as host, 0 when it runs as device |
| evt_i | input | 32 | One-cycle event pulses, one per status bit position |
| fifo_cond_i | input | 32 | Live FIFO conditions; only bits 4, 6 and 7 are used |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can land on the same latched bit in the same cycle: an incoming event pulse and a software write-1 clear. The bench provokes this by raising `evt_i` on bit 30 in the same cycle as a status write with bit 30 set. It then reads the word back and requires the bit to still be set. A second overlap drives `soft_rst` together with an all-ones event pulse and a mask write, and the result is judged by reading back the reset pattern and a zero mask.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] STS_ADDR = 12'h014;
    localparam logic [ADDR_W-1:0] MSK_ADDR = 12'h018;

    // Latched bits that come out of reset set
    localparam logic [DATA_W-1:0] STS_RESET      = 32'h1400_0020;
    // Bit classes
    localparam logic [DATA_W-1:0] W1C_BITS       = 32'hFFFF_FC2E;
    localparam logic [DATA_W-1:0] FIFO_BITS      = 32'h0000_00D0;
    localparam int                MODE_BIT       = 0;
    localparam logic [DATA_W-1:0] MODE_MASK      = DATA_W'(1) << MODE_BIT;
    localparam logic [DATA_W-1:0] RSVD_BITS      = ~(W1C_BITS | FIFO_BITS | MODE_MASK);
    // Mode validity
    localparam logic [DATA_W-1:0] HOST_ONLY_BITS = 32'h0300_0080;
    localparam logic [DATA_W-1:0] DEV_ONLY_BITS  = 32'h000F_F000;

    typedef enum logic {
        MODE_DEVICE = 1'b0,
        MODE_HOST   = 1'b1
    } op_mode_e;

    typedef struct packed {
        logic              sts_wr;
        logic              msk_wr;
        logic              sts_rd;
        logic              msk_rd;
        logic [DATA_W-1:0] data;
    } reg_access_t;

    // Bits that carry meaning in the given mode
    function automatic logic [DATA_W-1:0] mode_valid(input op_mode_e m);
        return (m == MODE_HOST) ? ~DEV_ONLY_BITS : ~HOST_ONLY_BITS;
    endfunction

    // Assemble the visible status word from its three sources
    function automatic logic [DATA_W-1:0] compose_status(
        input logic [DATA_W-1:0] latched,
        input logic [DATA_W-1:0] live,
        input op_mode_e          m
    );
        logic [DATA_W-1:0] w;
        w = (latched & W1C_BITS) | (live & FIFO_BITS);
        if (m == MODE_HOST) begin
            w = w | MODE_MASK;
        end
        return w;
    endfunction

endpackage

// File: rtl/esr_decode.sv
module esr_decode
    import evt_status_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter logic [AW-1:0] STS_A = STS_ADDR,
    parameter logic [AW-1:0] MSK_A = MSK_ADDR
) (
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output reg_access_t   acc
);
    logic hit_sts;
    logic hit_msk;

    always_comb begin
        hit_sts    = (addr == STS_A);
        hit_msk    = (addr == MSK_A);
        acc.sts_wr = wr_en & hit_sts;
        acc.msk_wr = wr_en & hit_msk;
        acc.sts_rd = rd_en & hit_sts;
        acc.msk_rd = rd_en & hit_msk;
        acc.data   = wdata;
    end
endmodule

// File: rtl/esr_latch_bank.sv
module esr_latch_bank
    import evt_status_pkg::*;
#(
    parameter int              DW    = DATA_W,
    parameter logic [DW-1:0]   W1C   = W1C_BITS,
    parameter logic [DW-1:0]   RSTV  = STS_RESET
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_rst,
    input  logic [DW-1:0] evt,
    input  logic [DW-1:0] clr,
    output logic [DW-1:0] q
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (W1C[i]) begin : g_w1c
            logic b_q;
            always_ff @(posedge clk) begin
                if (rst || soft_rst) begin
                    b_q <= RSTV[i];
                end else if (evt[i]) begin
                    b_q <= 1'b1;          // event beats a same-cycle clear
                end else if (clr[i]) begin
                    b_q <= 1'b0;
                end
            end
            assign q[i] = b_q;
        end else begin : g_none
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/esr_mask_reg.sv
module esr_mask_reg
    import evt_status_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_rst,
    input  logic          we,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end
endmodule

// File: rtl/esr_irq_merge.sv
module esr_irq_merge
    import evt_status_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int MBP = MODE_BIT
) (
    input  logic          host_mode,
    input  logic [DW-1:0] status,
    input  logic [DW-1:0] mask,
    output logic          irq
);
    logic [DW-1:0] valid;
    logic [DW-1:0] contrib;

    assign valid = mode_valid(op_mode_e'(host_mode));

    for (genvar i = 0; i < DW; i++) begin : g_term
        if (i == MBP) begin : g_mode
            assign contrib[i] = 1'b0;
        end else begin : g_evt
            assign contrib[i] = status[i] & mask[i] & valid[i];
        end
    end

    assign irq = |contrib;
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
    import evt_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              host_mode,
    input  logic [DATA_W-1:0] evt_i,
    input  logic [DATA_W-1:0] fifo_cond_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    reg_access_t       acc;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] sts_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] sts_view;

    esr_decode u_decode (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .acc   (acc)
    );

    assign clr_vec = acc.sts_wr ? (acc.data & W1C_BITS) : '0;

    esr_latch_bank u_latch (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .evt      (evt_i),
        .clr      (clr_vec),
        .q        (sts_q)
    );

    esr_mask_reg u_mask (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .we       (acc.msk_wr),
        .d        (acc.data),
        .q        (mask_q)
    );

    assign sts_view = compose_status(sts_q, fifo_cond_i, op_mode_e'(host_mode));

    always_comb begin
        if (acc.sts_rd) begin
            rdata = sts_view;
        end else if (acc.msk_rd) begin
            rdata = mask_q;
        end else begin
            rdata = '0;
        end
    end

    esr_irq_merge u_irq (
        .host_mode (host_mode),
        .status    (sts_view),
        .mask      (mask_q),
        .irq       (irq)
    );
endmodule

// File: rtl/esr_checker.sv
module esr_checker
    import evt_status_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              soft_rst,
    input logic              host_mode,
    input logic [DATA_W-1:0] evt_i,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic [DATA_W-1:0] sts_q,
    input logic [DATA_W-1:0] mask_q
);
    assert_soft_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
        $past(soft_rst) |-> (sts_q == STS_RESET && mask_q == '0));

    // R2 and R4: an event always leaves its bit set, a clear in the same cycle notwithstanding
    assert_event_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (!soft_rst && (evt_i & W1C_BITS) != '0)
        |=> ((sts_q & $past(evt_i & W1C_BITS)) == $past(evt_i & W1C_BITS)));

    assert_no_clear_without_write_R3: assert property (@(posedge clk) disable iff (rst)
        (!soft_rst && !(wr_en && addr == STS_ADDR))
        |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

    assert_mode_bit_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == STS_ADDR) |-> (rdata[MODE_BIT] == host_mode));

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == STS_ADDR) |-> ((rdata & RSVD_BITS) == '0));

    assert_mask_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == MSK_ADDR && !soft_rst) |=> (mask_q == $past(wdata)));

    assert_irq_needs_mask_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((mask_q & ~MODE_MASK) != '0));

    assert_idle_bus_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rdata == '0));
endmodule

bind evt_status_reg esr_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .host_mode (host_mode),
    .evt_i     (evt_i),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .irq       (irq),
    .sts_q     (sts_q),
    .mask_q    (mask_q)
);

// File: tb/test_evt_status_reg.sv
`timescale 1ns/1ps
module test_evt_status_reg;
    logic        clk = 1'b0;
    logic        rst;
    logic        soft_rst;
    logic        host_mode;
    logic [31:0] evt_i;
    logic [31:0] fifo_cond_i;
    logic        wr_en;
    logic        rd_en;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [11:0] A_STS = 12'h014;
    localparam logic [11:0] A_MSK = 12'h018;

    always #5 clk = ~clk;

    evt_status_reg i_evt_status_reg (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .host_mode(host_mode),
        .evt_i(evt_i), .fifo_cond_i(fifo_cond_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        #1;
        d = rdata;
        rd_en = 1'b0;
        #1;
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk);
        evt_i = v;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_STS, d); check("R1 reset status", d, 32'h1400_0020);
        rd(A_MSK, d); check("R1 reset mask", d, 32'h0);
        check("R9 reset irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_event_clear();
        logic [31:0] d;
        wr(A_STS, 32'hFFFF_FFFF);
        rd(A_STS, d); check("R3 init clear", d, 32'h0);
        pulse(32'h4000_0008);
        rd(A_STS, d); check("R2 events latched", d, 32'h4000_0008);
        wr(A_STS, 32'h0);
        rd(A_STS, d); check("R3 write zero keeps", d, 32'h4000_0008);
        wr(A_STS, 32'h0000_0008);
        rd(A_STS, d); check("R3 write one clears", d, 32'h4000_0000);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        @(negedge clk);
        evt_i = 32'h4000_0000; addr = A_STS; wdata = 32'h4000_0000; wr_en = 1'b1;
        @(negedge clk);
        evt_i = '0; wr_en = 1'b0;
        rd(A_STS, d); check("R4 event beats clear", d, 32'h4000_0000);
        wr(A_STS, 32'h4000_0000);
        rd(A_STS, d); check("R4 later clear", d, 32'h0);
    endtask

    task automatic t_fifo();
        logic [31:0] d;
        @(negedge clk);
        fifo_cond_i = 32'h0000_00D1;
        rd(A_STS, d); check("R5 live fifo bits", d, 32'h0000_00D0);
        wr(A_STS, 32'hFFFF_FFFF);
        rd(A_STS, d); check("R5 write ignored", d, 32'h0000_00D0);
        fifo_cond_i = '0;
        rd(A_STS, d); check("R5 fifo bits drop", d, 32'h0);
        pulse(32'h0000_00D0);
        rd(A_STS, d); check("R5 events ignored", d, 32'h0);
    endtask

    task automatic t_mode();
        logic [31:0] d;
        host_mode = 1'b1;
        rd(A_STS, d); check("R6 host bit", d, 32'h1);
        wr(A_STS, 32'h1);
        rd(A_STS, d); check("R6 write ignored", d, 32'h1);
        host_mode = 1'b0;
        rd(A_STS, d); check("R6 device bit", d, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        pulse(32'h0000_0300);
        rd(A_STS, d); check("R7 reserved zero", d, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(A_MSK, 32'hA5A5_5A5A);
        rd(A_MSK, d); check("R8 mask readback", d, 32'hA5A5_5A5A);
        wr(A_MSK, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        pulse(32'h0000_1000);
        check("R9 unmasked no irq", {31'b0, irq}, 32'h0);
        wr(A_MSK, 32'h0000_1000);
        check("R11 irq with mask", {31'b0, irq}, 32'h1);
        host_mode = 1'b1; #1;
        check("R9 device bit gated in host", {31'b0, irq}, 32'h0);
        rd(A_STS, d); check("R9 readback ungated", d, 32'h0000_1001);
        pulse(32'h0100_0000);
        wr(A_MSK, 32'h0100_0000);
        check("R9 host bit in host", {31'b0, irq}, 32'h1);
        host_mode = 1'b0; #1;
        check("R9 host bit gated in device", {31'b0, irq}, 32'h0);
        wr(A_STS, 32'hFFFF_FFFF);
        host_mode = 1'b1;
        wr(A_MSK, 32'h0000_0001);
        check("R9 mode bit never fires", {31'b0, irq}, 32'h0);
        host_mode = 1'b0;
        wr(A_MSK, 32'h0000_0030);
        fifo_cond_i = 32'h0000_0010; #1;
        check("R11 live fifo irq", {31'b0, irq}, 32'h1);
        fifo_cond_i = '0; #1;
        check("R11 fifo irq drops", {31'b0, irq}, 32'h0);
        pulse(32'h0000_0020);
        check("R11 event irq next edge", {31'b0, irq}, 32'h1);
        wr(A_STS, 32'h0000_0020);
        check("R9 irq after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_address();
        logic [31:0] d;
        pulse(32'h0000_0004);
        rd(12'h010, d); check("R10 other address", d, 32'h0);
        addr = A_STS; #1;
        check("R10 no read strobe", rdata, 32'h0);
        wr(12'h01C, 32'hFFFF_FFFF);
        wr(12'h010, 32'hFFFF_FFFF);
        rd(A_MSK, d); check("R10 stray write mask", d, 32'h0000_0030);
        rd(A_STS, d); check("R10 stray write status", d, 32'h0000_0004);
    endtask

    task automatic t_soft_reset();
        logic [31:0] d;
        @(negedge clk);
        soft_rst = 1'b1; evt_i = 32'hFFFF_FFFF;
        addr = A_MSK; wdata = 32'hFFFF_FFFF; wr_en = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0; evt_i = '0; wr_en = 1'b0;
        rd(A_STS, d); check("R1 soft reset status", d, 32'h1400_0020);
        rd(A_MSK, d); check("R1 soft reset mask", d, 32'h0);
    endtask

    initial begin
        rst = 1'b1; soft_rst = 1'b0; host_mode = 1'b0; evt_i = '0; fifo_cond_i = '0;
        wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_event_clear();
        t_collision();
        t_fifo();
        t_mode();
        t_reserved();
        t_mask();
        t_irq();
        t_address();
        t_soft_reset();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule